// File: doc/BRIEF.md
# Mailbox Channel Window Register Bank

This block holds the shared state of one mailbox link between a sending agent and a receiving agent. Each agent sees its own register port: a write strobe with address and data, and a read data bus that follows the read address within the same cycle. The link carries a parameter-chosen number of 32-bit channel windows, at most 124. Each window has one status word that both sides can see. The sender ORs bits into the word. The receiver clears bits and keeps a per-bit mask. Any unmasked bit that is set raises the receiver interrupt.

The sender can ask to be told when a window drains. A window whose status drops from nonzero to zero, while its interrupt enable is set, latches an interrupt flag. The flag stays set until the sender writes a one to clear it. Each side also has a frame area. It holds a window-count word, a revision word, four combined status words with one bit per window, frame event flags with enables and a clear, and on the sender side an access request and access ready pair.

The ports are plain register ports with no handshake. A write takes effect at the clock edge where the strobe is high, and the next read shows the new value.

Top module: `mbox_window_bank`

## Requirements
- R1: After reset, every window status bit is 0, every mask bit is 1, every window interrupt enable and flag is 0, access request and ready are 0, and both interrupts are low.
- R2: A write at sender window offset 0x0C ORs the written bits into that window's status, which both sides read at offset 0x00; bits already set stay set until the receiver clears them.
- R3: A write at receiver window offset 0x08 clears the written bits of the status; when a sender set and a receiver clear of the same bit land in the same cycle, the clear wins.
- R4: Receiver offset 0x14 sets mask bits, 0x18 clears them, 0x10 reads the mask, and 0x04 reads the status AND NOT the mask.
- R5: irq_rcv is high whenever any window has a nonzero masked status, and also when a receiver frame event flag is set with its enable bit set.
- R6: A sender window flag (read at 0x10, bit 0) is set in the cycle the status goes from nonzero to zero, if enable bit 0 at offset 0x18 is set. Writing 1 to bit 0 at offset 0x14 clears the flag. With the enable at 0 the flag never sets.
- R7: Combined status word k sits at frame offset 0xFA0+4k, and its bit j stands for window 32k+j. On the sender it shows the window flag. On the receiver it shows a nonzero masked status.
- R8: The word at 0xF80 reads the window count in bits 6:0. The word at 0xFCC reads the minor revision in bits 3:0 and the major revision in bits 7:4.
- R9: The sender writes bit 0 of the access request at 0xF88. The access ready bit at 0xF8C reads 1 one cycle after request and rcv_avail are both high, and 0 one cycle after either is low.
- R10: Each side's frame flag word at 0xF90 sets bit 0 one cycle after its watched level rises and bit 1 one cycle after it falls. The sender watches access ready and the receiver watches access request. Writing ones to 0xF94 clears the flags. At 0xF98, bits 1:0 enable the flags onto the side's interrupt, and sender bit 2 enables the combined window flags onto irq_snd.
- R11: Reads of windows at or above the implemented count, of reserved or write-only offsets, and of addresses whose low two bits are nonzero return 0. Writes to those places change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_we | input | 1 | Sender write strobe |
| snd_addr | input | 12 | Sender byte address |
| snd_wdata | input | 32 | Sender write data |
| snd_rdata | output | 32 | Sender read data for snd_addr |
| rcv_we | input | 1 | Receiver write strobe |
| rcv_addr | input | 12 | Receiver byte address |
| rcv_wdata | input | 32 | Receiver write data |
| rcv_rdata | output | 32 | Receiver read data for rcv_addr |
| rcv_avail | input | 1 | Receiver side available for access |
| irq_rcv | output | 1 | Receiver interrupt |
| irq_snd | output | 1 | Sender interrupt |

## Verification
Every implemented window, 40 of them spanning two combined words, goes through the same sequence with its own bit pattern. The sequence sets bits, ORs in more bits, opens and closes mask bits, then drains the window with its interrupt enabled. Because the patterns differ by window, a decode fault that aliases two windows or misplaces a combined bit shows up. Separate cases then cover the following:
- a drain with the enable off, which separates edge-triggered flagging from level-triggered flagging;
- a set and a clear landing in the same cycle, which fixes the priority between them;
- writes to windows beyond the implemented count, to reserved offsets and to misaligned addresses;
- the access request and ready sequence, walked while rcv_avail is toggled, which pins down the one-cycle lag and the rise and fall flags.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int AW      = 12;
  localparam int DW      = 32;
  localparam int WIN_MAX = 124;
  localparam int CMB_N   = 4;

  typedef logic [DW-1:0] word_t;
  typedef logic [AW-1:0] addr_t;

  // per-window offsets, sender view
  localparam logic [4:0] S_STAT = 5'h00;
  localparam logic [4:0] S_SET  = 5'h0C;
  localparam logic [4:0] S_IST  = 5'h10;
  localparam logic [4:0] S_ICLR = 5'h14;
  localparam logic [4:0] S_IEN  = 5'h18;

  // per-window offsets, receiver view
  localparam logic [4:0] R_STAT = 5'h00;
  localparam logic [4:0] R_MSTA = 5'h04;
  localparam logic [4:0] R_CLR  = 5'h08;
  localparam logic [4:0] R_MASK = 5'h10;
  localparam logic [4:0] R_MSET = 5'h14;
  localparam logic [4:0] R_MCLR = 5'h18;

  // frame area
  localparam addr_t F_CFG  = 12'hF80;
  localparam addr_t F_AREQ = 12'hF88;
  localparam addr_t F_ARDY = 12'hF8C;
  localparam addr_t F_IST  = 12'hF90;
  localparam addr_t F_ICLR = 12'hF94;
  localparam addr_t F_IEN  = 12'hF98;
  localparam addr_t F_CMB0 = 12'hFA0;
  localparam addr_t F_AID  = 12'hFCC;
endpackage

// File: rtl/mbox_win_cell.sv
module mbox_win_cell
  import mbox_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_we,
  input  word_t set_bits,
  input  logic  clr_we,
  input  word_t clr_bits,
  input  logic  mset_we,
  input  word_t mset_bits,
  input  logic  mclr_we,
  input  word_t mclr_bits,
  input  logic  ien_we,
  input  logic  ien_bit,
  input  logic  iclr_we,
  input  logic  iclr_bit,
  output word_t stat_q,
  output word_t mask_q,
  output word_t masked,
  output logic  ien_q,
  output logic  iflag_q
);
  word_t stat_d, mask_d;
  logic  drained;

  always_comb begin
    stat_d = stat_q;
    if (set_we) stat_d = stat_d | set_bits;
    if (clr_we) stat_d = stat_d & ~clr_bits;   // clear applied last: it wins
    mask_d = mask_q;
    if (mset_we) mask_d = mask_d | mset_bits;
    if (mclr_we) mask_d = mask_d & ~mclr_bits;
  end

  assign drained = (stat_q != '0) && (stat_d == '0) && ien_q;
  assign masked  = stat_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      mask_q  <= '1;
      ien_q   <= 1'b0;
      iflag_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      if (ien_we) ien_q <= ien_bit;
      if (drained)                 iflag_q <= 1'b1;
      else if (iclr_we && iclr_bit) iflag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_frame_ctl.sv
module mbox_frame_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  logic       en_we,
  input  logic [2:0] en_bits,
  input  logic       clr_we,
  input  logic [1:0] clr_bits,
  output logic [2:0] en_q,
  output logic [1:0] st_q,
  output logic       ev_irq
);
  logic level_q;
  logic rise, fall;
  logic [1:0] st_d;

  assign rise = level & ~level_q;
  assign fall = ~level & level_q;

  always_comb begin
    st_d = st_q;
    if (clr_we) st_d = st_d & ~clr_bits;
    st_d = st_d | {fall, rise};
  end

  assign ev_irq = |(st_q & en_q[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      st_q    <= '0;
      en_q    <= '0;
    end else begin
      level_q <= level;
      st_q    <= st_d;
      if (en_we) en_q <= en_bits;
    end
  end
endmodule

// File: rtl/mbox_window_bank.sv
module mbox_window_bank
  import mbox_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int MINOR_REV = 1,
  parameter int MAJOR_REV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        snd_we,
  input  logic [11:0] snd_addr,
  input  logic [31:0] snd_wdata,
  output logic [31:0] snd_rdata,
  input  logic        rcv_we,
  input  logic [11:0] rcv_addr,
  input  logic [31:0] rcv_wdata,
  output logic [31:0] rcv_rdata,
  input  logic        rcv_avail,
  output logic        irq_rcv,
  output logic        irq_snd
);
  localparam int IDX_W = 7;
  localparam word_t CFG_WORD = word_t'(NUM_WIN) & 32'h7F;
  localparam word_t AID_WORD = {24'b0, 4'(MAJOR_REV), 4'(MINOR_REV)};

  logic [NUM_WIN-1:0][DW-1:0] win_stat, win_mask, win_masked;
  logic [NUM_WIN-1:0]         win_ien, win_iflag, win_clr_hit;
  logic [CMB_N-1:0][DW-1:0]   snd_cmb, rcv_cmb;

  logic [IDX_W-1:0] s_idx, r_idx;
  logic [4:0]       s_off, r_off;
  logic             s_ok, r_ok, s_in_win, r_in_win;

  logic acc_req, acc_rdy;
  logic [2:0] s_fen, r_fen;
  logic [1:0] s_fst, r_fst;
  logic s_ev, r_ev;

  assign s_idx    = snd_addr[11:5];
  assign r_idx    = rcv_addr[11:5];
  assign s_off    = snd_addr[4:0];
  assign r_off    = rcv_addr[4:0];
  assign s_ok     = (snd_addr[1:0] == 2'b00);
  assign r_ok     = (rcv_addr[1:0] == 2'b00);
  assign s_in_win = (snd_addr < F_CFG);
  assign r_in_win = (rcv_addr < F_CFG);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic s_hit, r_hit;
    assign s_hit = snd_we && s_ok && s_in_win && (s_idx == IDX_W'(w));
    assign r_hit = rcv_we && r_ok && r_in_win && (r_idx == IDX_W'(w));
    assign win_clr_hit[w] = r_hit && (r_off == R_CLR);

    mbox_win_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (s_hit && (s_off == S_SET)),
      .set_bits (snd_wdata),
      .clr_we   (win_clr_hit[w]),
      .clr_bits (rcv_wdata),
      .mset_we  (r_hit && (r_off == R_MSET)),
      .mset_bits(rcv_wdata),
      .mclr_we  (r_hit && (r_off == R_MCLR)),
      .mclr_bits(rcv_wdata),
      .ien_we   (s_hit && (s_off == S_IEN)),
      .ien_bit  (snd_wdata[0]),
      .iclr_we  (s_hit && (s_off == S_ICLR)),
      .iclr_bit (snd_wdata[0]),
      .stat_q   (win_stat[w]),
      .mask_q   (win_mask[w]),
      .masked   (win_masked[w]),
      .ien_q    (win_ien[w]),
      .iflag_q  (win_iflag[w])
    );
  end

  // combined per-window status, window w -> word w/32, bit w%32
  always_comb begin
    snd_cmb = '0;
    rcv_cmb = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      snd_cmb[w / 32][w % 32] = win_iflag[w];
      rcv_cmb[w / 32][w % 32] = |win_masked[w];
    end
  end

  // access handshake
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_req <= 1'b0;
      acc_rdy <= 1'b0;
    end else begin
      if (snd_we && snd_addr == F_AREQ) acc_req <= snd_wdata[0];
      acc_rdy <= acc_req & rcv_avail;
    end
  end

  mbox_frame_ctl u_snd_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (acc_rdy),
    .en_we   (snd_we && snd_addr == F_IEN),
    .en_bits (snd_wdata[2:0]),
    .clr_we  (snd_we && snd_addr == F_ICLR),
    .clr_bits(snd_wdata[1:0]),
    .en_q    (s_fen),
    .st_q    (s_fst),
    .ev_irq  (s_ev)
  );

  mbox_frame_ctl u_rcv_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (acc_req),
    .en_we   (rcv_we && rcv_addr == F_IEN),
    .en_bits (rcv_wdata[2:0]),
    .clr_we  (rcv_we && rcv_addr == F_ICLR),
    .clr_bits(rcv_wdata[1:0]),
    .en_q    (r_fen),
    .st_q    (r_fst),
    .ev_irq  (r_ev)
  );

  assign irq_rcv = (|rcv_cmb) | r_ev;
  assign irq_snd = (s_fen[2] & (|win_iflag)) | s_ev;

  // sender read path
  always_comb begin
    snd_rdata = '0;
    if (s_ok) begin
      if (s_in_win) begin
        for (int w = 0; w < NUM_WIN; w++) begin
          if (s_idx == IDX_W'(w)) begin
            case (s_off)
              S_STAT:  snd_rdata = win_stat[w];
              S_IST:   snd_rdata = {31'b0, win_iflag[w]};
              S_IEN:   snd_rdata = {31'b0, win_ien[w]};
              default: snd_rdata = '0;
            endcase
          end
        end
      end else begin
        case (snd_addr)
          F_CFG:   snd_rdata = CFG_WORD;
          F_AREQ:  snd_rdata = {31'b0, acc_req};
          F_ARDY:  snd_rdata = {31'b0, acc_rdy};
          F_IST:   snd_rdata = {30'b0, s_fst};
          F_IEN:   snd_rdata = {29'b0, s_fen};
          F_AID:   snd_rdata = AID_WORD;
          default: begin
            if (snd_addr >= F_CMB0 && snd_addr < F_CMB0 + 12'd16)
              snd_rdata = snd_cmb[snd_addr[3:2]];
          end
        endcase
      end
    end
  end

  // receiver read path
  always_comb begin
    rcv_rdata = '0;
    if (r_ok) begin
      if (r_in_win) begin
        for (int w = 0; w < NUM_WIN; w++) begin
          if (r_idx == IDX_W'(w)) begin
            case (r_off)
              R_STAT:  rcv_rdata = win_stat[w];
              R_MSTA:  rcv_rdata = win_masked[w];
              R_MASK:  rcv_rdata = win_mask[w];
              default: rcv_rdata = '0;
            endcase
          end
        end
      end else begin
        case (rcv_addr)
          F_CFG:   rcv_rdata = CFG_WORD;
          F_IST:   rcv_rdata = {30'b0, r_fst};
          F_IEN:   rcv_rdata = {29'b0, r_fen};
          F_AID:   rcv_rdata = AID_WORD;
          default: begin
            if (rcv_addr >= F_CMB0 && rcv_addr < F_CMB0 + 12'd16)
              rcv_rdata = rcv_cmb[rcv_addr[3:2]];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mbox_window_bank_chk.sv
module mbox_window_bank_chk #(
  parameter int NUM_WIN = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_WIN-1:0][31:0]  stat,
  input logic [NUM_WIN-1:0][31:0]  masked,
  input logic [NUM_WIN-1:0]        clr_hit,
  input logic [NUM_WIN-1:0]        ien,
  input logic [NUM_WIN-1:0]        iflag,
  input logic                      irq_rcv,
  input logic                      acc_req,
  input logic                      rcv_avail,
  input logic                      acc_rdy
);
  logic any_masked;
  always_comb begin
    any_masked = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) any_masked = any_masked | (|masked[w]);
  end

  // R5: a pending unmasked bit always reaches the receiver interrupt
  a_r5_irq_follows_masked: assert property (@(posedge clk) disable iff (!rst_n)
    any_masked |-> irq_rcv);

  // R9: ready tracks request and availability with one cycle of lag
  a_r9_ready_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && rcv_avail) |=> acc_rdy);
  a_r9_ready_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_req && rcv_avail) |=> !acc_rdy);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
    // R2: status bits only drop when the receiver clears that window
    a_r2_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_hit[w] |=> ((stat[w] & $past(stat[w])) == $past(stat[w])));
    // R6: a flag rises only on a drain to zero
    a_r6_flag_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iflag[w]) |-> ($past(stat[w]) != 32'h0) && (stat[w] == 32'h0));
    // R6: no flag while the enable is off
    a_r6_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien[w] && !iflag[w]) |=> !iflag[w]);
  end
endmodule

bind mbox_window_bank mbox_window_bank_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stat     (win_stat),
  .masked   (win_masked),
  .clr_hit  (win_clr_hit),
  .ien      (win_ien),
  .iflag    (win_iflag),
  .irq_rcv  (irq_rcv),
  .acc_req  (acc_req),
  .rcv_avail(rcv_avail),
  .acc_rdy  (acc_rdy)
);

// File: tb/test_mbox_window_bank.sv
module test_mbox_window_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snd_we = 1'b0, rcv_we = 1'b0, rcv_avail = 1'b0;
  logic [11:0] snd_addr = '0, rcv_addr = '0;
  logic [31:0] snd_wdata = '0, rcv_wdata = '0;
  logic [31:0] snd_rdata, rcv_rdata;
  logic        irq_rcv, irq_snd;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_window_bank #(.NUM_WIN(NW), .MINOR_REV(1), .MAJOR_REV(2)) i_mbox_window_bank (
    .clk(clk), .rst_n(rst_n),
    .snd_we(snd_we), .snd_addr(snd_addr), .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
    .rcv_we(rcv_we), .rcv_addr(rcv_addr), .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
    .rcv_avail(rcv_avail), .irq_rcv(irq_rcv), .irq_snd(irq_snd)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic swr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); snd_we = 1'b1; snd_addr = a; snd_wdata = d;
    @(negedge clk); snd_we = 1'b0;
  endtask

  task automatic rwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); rcv_we = 1'b1; rcv_addr = a; rcv_wdata = d;
    @(negedge clk); rcv_we = 1'b0;
  endtask

  task automatic srd(input logic [11:0] a, output logic [31:0] d);
    snd_addr = a; #1 d = snd_rdata;
  endtask

  task automatic rrd(input logic [11:0] a, output logic [31:0] d);
    rcv_addr = a; #1 d = rcv_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, p, st;
    logic [11:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state over all windows
    for (int w = 0; w < NW; w++) begin
      b = 12'(w * 32);
      srd(b, d);              check("R1 status", d, 32'h0);
      rrd(b + 12'h10, d);     check("R1 mask", d, 32'hFFFF_FFFF);
      srd(b + 12'h18, d);     check("R1 int enable", d, 32'h0);
    end
    check("R1 irq_rcv", {31'b0, irq_rcv}, 32'h0);
    check("R1 irq_snd", {31'b0, irq_snd}, 32'h0);
    srd(12'hF8C, d);          check("R1 ready", d, 32'h0);

    // R8 identification
    srd(12'hF80, d);          check("R8 cfg sender", d, 32'(NW));
    rrd(12'hF80, d);          check("R8 cfg receiver", d, 32'(NW));
    srd(12'hFCC, d);          check("R8 arch id", d, 32'h21);

    // main sweep per window
    for (int w = 0; w < NW; w++) begin
      b = 12'(w * 32);
      p = {8'(w) + 8'h5A, 8'hC3, 8'(w), 8'h01};
      swr(b + 12'h0C, p);
      srd(b, d);              check("R2 sender status", d, p);
      rrd(b, d);              check("R2 receiver status", d, p);
      rrd(b + 12'h04, d);     check("R4 fully masked", d, 32'h0);
      check("R5 irq low while masked", {31'b0, irq_rcv}, 32'h0);
      swr(b + 12'h0C, 32'h0000_F000);
      st = p | 32'h0000_F000;
      srd(b, d);              check("R2 OR of second set", d, st);
      rwr(b + 12'h18, 32'h0000_00FF);
      rrd(b + 12'h10, d);     check("R4 mask after clear", d, 32'hFFFF_FF00);
      rrd(b + 12'h04, d);     check("R4 masked status", d, st & 32'hFF);
      check("R5 irq high", {31'b0, irq_rcv}, 32'h1);
      rrd(12'hFA0 + 12'(4 * (w / 32)), d);
      check("R7 receiver combined bit", d, 32'h1 << (w % 32));
      rwr(b + 12'h14, 32'h0000_00FF);
      rrd(b + 12'h04, d);     check("R4 remasked", d, 32'h0);
      check("R5 irq low again", {31'b0, irq_rcv}, 32'h0);
      swr(b + 12'h18, 32'h1);
      rwr(b + 12'h08, 32'hFFFF_FFFF);
      srd(b, d);              check("R3 cleared", d, 32'h0);
      srd(b + 12'h10, d);     check("R6 flag on drain", d, 32'h1);
      srd(12'hFA0 + 12'(4 * (w / 32)), d);
      check("R7 sender combined bit", d, 32'h1 << (w % 32));
      check("R10 irq_snd gated off", {31'b0, irq_snd}, 32'h0);
      swr(b + 12'h14, 32'h1);
      srd(b + 12'h10, d);     check("R6 flag cleared", d, 32'h0);
      swr(b + 12'h18, 32'h0);
    end

    // R6 drain with enable off
    swr(12'h06C, 32'h0000_0003);
    rwr(12'h068, 32'h0000_0003);
    srd(12'h070, d);          check("R6 no flag when disabled", d, 32'h0);

    // R3 same-cycle set and clear: clear wins
    swr(12'h0AC, 32'h0000_000F);
    @(negedge clk);
    snd_we = 1'b1; snd_addr = 12'h0AC; snd_wdata = 32'h0000_00F0;
    rcv_we = 1'b1; rcv_addr = 12'h0A8; rcv_wdata = 32'h0000_0030;
    @(negedge clk);
    snd_we = 1'b0; rcv_we = 1'b0;
    srd(12'h0A0, d);          check("R3 clear wins", d, 32'h0000_00CF);
    rwr(12'h0A8, 32'hFFFF_FFFF);

    // R10 combined enable bit 2 on the sender
    swr(12'h0F8, 32'h1);
    swr(12'h0EC, 32'h10);
    rwr(12'h0E8, 32'h10);
    check("R10 irq_snd needs bit2", {31'b0, irq_snd}, 32'h0);
    swr(12'hF98, 32'h4);
    #1 check("R10 irq_snd combined", {31'b0, irq_snd}, 32'h1);
    swr(12'h0F4, 32'h1);
    #1 check("R10 irq_snd after flag clear", {31'b0, irq_snd}, 32'h0);
    swr(12'hF98, 32'h0);
    swr(12'h0F8, 32'h0);

    // R11 unimplemented window, reserved offsets, misaligned address
    swr(12'(50 * 32) + 12'h0C, 32'hFFFF_FFFF);
    srd(12'(50 * 32), d);     check("R11 unimplemented sender", d, 32'h0);
    rrd(12'(50 * 32), d);     check("R11 unimplemented receiver", d, 32'h0);
    swr(12'h004, 32'hFFFF_FFFF);
    srd(12'h004, d);          check("R11 reserved read", d, 32'h0);
    swr(12'h00D, 32'hFFFF_FFFF);
    srd(12'h000, d);          check("R11 writes ignored", d, 32'h0);
    rwr(12'h00C, 32'hFFFF_FFFF);
    rwr(12'h015, 32'hFFFF_FFFF);
    rrd(12'h010, d);          check("R11 mask kept", d, 32'hFFFF_FFFF);
    srd(12'h00C, d);          check("R11 write-only reads zero", d, 32'h0);

    // R9 / R10 access handshake
    swr(12'hF88, 32'h1);
    @(negedge clk);
    srd(12'hF8C, d);          check("R9 no ready without avail", d, 32'h0);
    rrd(12'hF90, d);          check("R10 receiver sees request rise", d, 32'h1);
    rwr(12'hF98, 32'h1);
    #1 check("R10 receiver event irq", {31'b0, irq_rcv}, 32'h1);
    rwr(12'hF94, 32'h3);
    #1 check("R10 receiver flag cleared", {31'b0, irq_rcv}, 32'h0);
    rwr(12'hF98, 32'h0);
    rcv_avail = 1'b1;
    @(negedge clk);
    srd(12'hF8C, d);          check("R9 ready one cycle later", d, 32'h1);
    @(negedge clk);
    srd(12'hF90, d);          check("R10 sender ready rise", d, 32'h1);
    check("R10 flag not enabled", {31'b0, irq_snd}, 32'h0);
    swr(12'hF98, 32'h1);
    #1 check("R10 sender event irq", {31'b0, irq_snd}, 32'h1);
    swr(12'hF94, 32'h1);
    srd(12'hF90, d);          check("R10 sender flag cleared", d, 32'h0);
    check("R10 irq dropped", {31'b0, irq_snd}, 32'h0);
    rcv_avail = 1'b0;
    @(negedge clk);
    srd(12'hF8C, d);          check("R9 ready falls", d, 32'h0);
    @(negedge clk);
    srd(12'hF90, d);          check("R10 sender ready fall", d, 32'h2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule